// File: doc/BRIEF.md
# Four-Input Fixed-Point Softmax Approximator

This block turns four signed fixed-point scores into four probability-like weights, entirely in combinational logic. Each score is an 8-bit two's-complement number with four fraction bits, so it spans -8.0 to +7.9375. Each weight is an unsigned 8-bit fraction where 256 stands for 1.0.

The block first finds the largest score by signed comparison. It subtracts that peak from every score, counting the difference in raw input steps. Each difference then goes through a five-piece integer linear curve that stands in for the exponential, and the result is clamped to 0..255. In the last stage each clamped term is scaled by 256 and divided by the sum of all four terms, truncating, and the quotient is capped at 255. A zero sum would force every weight to 64, but this case cannot occur at the ports, because the peak term is always 255.

There is no clock, reset or register anywhere in the path. The block is meant to sit between a scoring stage and a consumer in the same cycle.

Top module: `softmax4_q44`

## Requirements
- R1: The peak is chosen by signed comparison. With scores {-1, +1, -1, -1} (raw 0xF0, 0x10, 0xF0, 0xF0), the +1 input is treated as the peak and has difference 0, while the others have difference -32.
- R2: For a difference d with -4 < d <= 0, the term is 256 + 16·d before clamping.
- R3: For -8 < d <= -4, the term is 192 + 12·(d+4). For -16 < d <= -8, it is 144 + 9·(d+8).
- R4: For -32 < d <= -16, the term is 92 + floor((d+16)·92 / 16). For -64 < d <= -32, it is 34 + floor((d+32)·34 / 16). Both divisions round toward minus infinity, as an arithmetic right shift does, and a negative result then clamps to 0.
- R5: A difference of -64 or less gives a term of 0, so that input's weight is 0.
- R6: Every term is clamped to 0..255, so a difference of 0 gives 255 and not 256.
- R7: At least one output is 64 or more, because the peak term 255 is at least a quarter of any sum.
- R8: Each output equals min(255, floor(term·256 / sum)). A lone peak whose three partners all have terms of 0 gives 255.
- R9: Outputs follow inputs with no clock. A new vector is fully reflected 1 ns after it is applied.
- R10: Inputs with equal scores get equal outputs. Four equal scores give 64 on every output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| score_0 | input | 8 | Score 0, signed Q4.4 |
| score_1 | input | 8 | Score 1, signed Q4.4 |
| score_2 | input | 8 | Score 2, signed Q4.4 |
| score_3 | input | 8 | Score 3, signed Q4.4 |
| prob_0 | output | 8 | Weight 0, unsigned Q0.8 |
| prob_1 | output | 8 | Weight 1, unsigned Q0.8 |
| prob_2 | output | 8 | Weight 2, unsigned Q0.8 |
| prob_3 | output | 8 | Weight 3, unsigned Q0.8 |

## Verification
Every time the ports settle, the assertions check four things:
- equal scores give equal weights;
- the weights add up to no more than 256;
- at least one weight reaches 64;
- some internal term equals 255, and a term of 0 gives a weight of 0.

The exact value of each curve segment cannot be shown by a property. The same holds for the floor rounding of the two shifted segments and the signed choice of peak. Only the bench's directed vectors at the segment boundaries, together with random vectors clustered to land in every segment, show those against independently computed results.

// File: rtl/softmax4_pkg.sv
package softmax4_pkg;
  localparam int N_IN  = 4;
  localparam int IN_W  = 8;
  localparam int OUT_W = 8;
  // difference needs one extra bit: it can reach -(2**IN_W - 1)
  localparam int DIFF_W = IN_W + 1;
  localparam int SUM_W  = OUT_W + $clog2(N_IN);
  localparam int QUO_W  = 2 * OUT_W;
endpackage

// File: rtl/sm_peak_sub.sv
module sm_peak_sub
  import softmax4_pkg::*;
#(
  parameter int N  = N_IN,
  parameter int IW = IN_W,
  parameter int DW = DIFF_W
) (
  input  logic [N-1:0][IW-1:0] score,
  output logic [N-1:0][DW-1:0] diff
);
  logic signed [IW-1:0] peak;

  always_comb begin
    peak = $signed(score[0]);
    for (int i = 1; i < N; i++) begin
      if ($signed(score[i]) > peak) peak = $signed(score[i]);
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_sub
    assign diff[g] = DW'($signed(score[g])) - DW'(peak);
  end
endmodule

// File: rtl/sm_exp_term.sv
module sm_exp_term
  import softmax4_pkg::*;
#(
  parameter int DW = DIFF_W,
  parameter int OW = OUT_W
) (
  input  logic [DW-1:0] diff,
  output logic [OW-1:0] term
);
  localparam int TMAX = (1 << OW) - 1;

  int dv;
  int acc;

  always_comb begin
    dv = int'($signed(diff));
    if (dv > -4)       acc = 256 + dv * 16;
    else if (dv > -8)  acc = 192 + (dv + 4) * 12;
    else if (dv > -16) acc = 144 + (dv + 8) * 9;
    else if (dv > -32) acc = 92 + (((dv + 16) * 92) >>> 4);
    else if (dv > -64) acc = 34 + (((dv + 32) * 34) >>> 4);
    else               acc = 0;
    if (acc < 0)         term = '0;
    else if (acc > TMAX) term = OW'(TMAX);
    else                 term = acc[OW-1:0];
  end
endmodule

// File: rtl/sm_normalize.sv
module sm_normalize
  import softmax4_pkg::*;
#(
  parameter int N  = N_IN,
  parameter int OW = OUT_W,
  parameter int SW = SUM_W,
  parameter int QW = QUO_W
) (
  input  logic [N-1:0][OW-1:0] term,
  output logic [N-1:0][OW-1:0] prob
);
  localparam int TMAX     = (1 << OW) - 1;
  localparam int FALLBACK = 1 << (OW - 2);

  logic [SW-1:0] sum;
  logic [QW-1:0] divisor;

  always_comb begin
    sum = '0;
    for (int i = 0; i < N; i++) sum = sum + SW'(term[i]);
  end

  assign divisor = (sum == '0) ? QW'(1) : QW'(sum);

  for (genvar g = 0; g < N; g++) begin : g_div
    logic [QW-1:0] num;
    logic [QW-1:0] quo;
    assign num = {term[g], {(QW - OW){1'b0}}};
    assign quo = num / divisor;
    always_comb begin
      if (sum == '0)               prob[g] = OW'(FALLBACK);
      else if (quo > QW'(TMAX))    prob[g] = OW'(TMAX);
      else                         prob[g] = quo[OW-1:0];
    end
  end
endmodule

// File: rtl/softmax4_q44.sv
module softmax4_q44
  import softmax4_pkg::*;
(
  input  logic [IN_W-1:0]  score_0,
  input  logic [IN_W-1:0]  score_1,
  input  logic [IN_W-1:0]  score_2,
  input  logic [IN_W-1:0]  score_3,
  output logic [OUT_W-1:0] prob_0,
  output logic [OUT_W-1:0] prob_1,
  output logic [OUT_W-1:0] prob_2,
  output logic [OUT_W-1:0] prob_3
);
  logic [N_IN-1:0][IN_W-1:0]   score_v;
  logic [N_IN-1:0][DIFF_W-1:0] diff_w;
  logic [N_IN-1:0][OUT_W-1:0]  term_w;
  logic [N_IN-1:0][OUT_W-1:0]  prob_v;

  assign score_v = {score_3, score_2, score_1, score_0};

  sm_peak_sub #(.N(N_IN), .IW(IN_W), .DW(DIFF_W)) u_peak (
    .score(score_v),
    .diff (diff_w)
  );

  for (genvar g = 0; g < N_IN; g++) begin : g_exp
    sm_exp_term #(.DW(DIFF_W), .OW(OUT_W)) u_exp (
      .diff(diff_w[g]),
      .term(term_w[g])
    );
  end

  sm_normalize #(.N(N_IN), .OW(OUT_W), .SW(SUM_W), .QW(QUO_W)) u_norm (
    .term(term_w),
    .prob(prob_v)
  );

  assign prob_0 = prob_v[0];
  assign prob_1 = prob_v[1];
  assign prob_2 = prob_v[2];
  assign prob_3 = prob_v[3];
endmodule

// File: rtl/sm_checker.sv
module sm_checker
  import softmax4_pkg::*;
(
  input logic [IN_W-1:0]             score_0,
  input logic [IN_W-1:0]             score_1,
  input logic [IN_W-1:0]             score_2,
  input logic [IN_W-1:0]             score_3,
  input logic [OUT_W-1:0]            prob_0,
  input logic [OUT_W-1:0]            prob_1,
  input logic [OUT_W-1:0]            prob_2,
  input logic [OUT_W-1:0]            prob_3,
  input logic [N_IN-1:0][OUT_W-1:0]  term
);
  localparam int TMAX = (1 << OUT_W) - 1;

  logic [N_IN-1:0][IN_W-1:0]  sc;
  logic [N_IN-1:0][OUT_W-1:0] pr;
  assign sc = {score_3, score_2, score_1, score_0};
  assign pr = {prob_3, prob_2, prob_1, prob_0};

  always_comb begin
    if (!$isunknown({sc, pr, term})) begin
      int total;
      int big;
      int top;
      total = 0;
      big   = 0;
      top   = 0;
      for (int i = 0; i < N_IN; i++) begin
        total = total + int'(pr[i]);
        if (int'(pr[i]) >= (1 << (OUT_W - 2))) big = 1;
        if (int'(term[i]) == TMAX) top = 1;
      end
      // R10: equal scores give equal weights
      p_tie_equal_r10: assert ((sc[0] != sc[1]) || (pr[0] == pr[1]))
        else $error("tie between inputs 0 and 1 gave unequal weights");
      // R8: truncating division keeps the weights within 256 in total
      p_sum_bound_r8: assert (total <= (1 << OUT_W))
        else $error("weights add up to %0d", total);
      // R7: the peak weight never falls below a quarter
      p_peak_floor_r7: assert (big == 1)
        else $error("no weight reaches a quarter");
      // R6: the peak term clamps to full scale
      p_peak_term_r6: assert (top == 1)
        else $error("no term at full scale");
      // R5: a zero term yields a zero weight
      p_zero_term_r5: assert ((term[0] != '0) || (pr[0] == '0))
        else $error("zero term gave nonzero weight");
    end
  end
endmodule

bind softmax4_q44 sm_checker u_chk (
  .score_0(score_0),
  .score_1(score_1),
  .score_2(score_2),
  .score_3(score_3),
  .prob_0 (prob_0),
  .prob_1 (prob_1),
  .prob_2 (prob_2),
  .prob_3 (prob_3),
  .term   (term_w)
);

// File: tb/sim_softmax4_q44.sv
`timescale 1ns/1ps
module sim_softmax4_q44;
  logic clk;
  logic [7:0] s0, s1, s2, s3;
  logic [7:0] p0, p1, p2, p3;
  int errors = 0;
  int checks = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  softmax4_q44 u0 (
    .score_0(s0), .score_1(s1), .score_2(s2), .score_3(s3),
    .prob_0(p0), .prob_1(p1), .prob_2(p2), .prob_3(p3)
  );

  function automatic int fl16(int v);
    int q;
    q = v / 16;
    if ((v < 0) && (v % 16 != 0)) q = q - 1;
    return q;
  endfunction

  function automatic int ref_term(int d);
    int e;
    if (d >= -3)       e = 256 + 16 * d;
    else if (d >= -7)  e = 192 + 12 * (d + 4);
    else if (d >= -15) e = 144 + 9 * (d + 8);
    else if (d >= -31) e = 92 + fl16((d + 16) * 92);
    else if (d >= -63) e = 34 + fl16((d + 32) * 34);
    else               e = 0;
    if (e < 0) e = 0;
    if (e > 255) e = 255;
    return e;
  endfunction

  task automatic apply(input int a, input int b, input int c, input int d, input string tag);
    int x[4];
    int e[4];
    int got[4];
    int m, sum, y;
    x[0] = a; x[1] = b; x[2] = c; x[3] = d;
    s0 = 8'(a); s1 = 8'(b); s2 = 8'(c); s3 = 8'(d);
    #1;
    got[0] = int'(p0); got[1] = int'(p1); got[2] = int'(p2); got[3] = int'(p3);
    m = x[0];
    for (int i = 1; i < 4; i++) if (x[i] > m) m = x[i];
    sum = 0;
    for (int i = 0; i < 4; i++) begin
      e[i] = ref_term(x[i] - m);
      sum += e[i];
    end
    for (int i = 0; i < 4; i++) begin
      if (sum == 0) y = 64;
      else begin
        y = (e[i] * 256) / sum;
        if (y > 255) y = 255;
      end
      checks++;
      if (got[i] != y) begin
        errors++;
        $display("FAIL %s: in=(%0d,%0d,%0d,%0d) out%0d actual=%0d expected=%0d",
                 tag, a, b, c, d, i, got[i], y);
      end
    end
    #4;
  endtask

  initial begin
    s0 = 8'd0; s1 = 8'd0; s2 = 8'd0; s3 = 8'd0;
    void'($urandom(32'h5EED_0042));
    #1;
    // reset-free start: all-zero vector, R10 gives 64 everywhere
    apply(0, 0, 0, 0, "R10 all zero");
    apply(-1 * 16, 16, -16, -16, "R1 signed peak");
    apply(-128, -1, -100, -5, "R1 all negative");
    apply(0, -1, -2, -3, "R2 top segment");
    apply(0, -4, -7, -8, "R3 second and third segment");
    apply(0, -15, -16, -31, "R4 boundary at -16");
    apply(0, -32, -33, -63, "R4 floor rounding");
    apply(0, -17, -47, -20, "R4 odd products");
    apply(0, -64, -65, -128, "R5 far below peak");
    apply(127, -128, -128, -128, "R8 lone peak saturates");
    apply(0, 0, -64, -64, "R6 clamp of peak");
    apply(37, 37, 37, 37, "R10 four-way tie");
    apply(-8, -8, -9, -60, "R7 peak floor");
    for (int n = 0; n < 3000; n++) begin
      int base, a, b, c, d;
      if (n % 2 == 0) begin
        a = int'($signed(8'($urandom)));
        b = int'($signed(8'($urandom)));
        c = int'($signed(8'($urandom)));
        d = int'($signed(8'($urandom)));
      end else begin
        base = int'($urandom_range(127, 0)) - 64;
        a = base - int'($urandom_range(70, 0));
        b = base - int'($urandom_range(70, 0));
        c = base - int'($urandom_range(40, 0));
        d = base;
        if (a < -128) a = -128;
        if (b < -128) b = -128;
        if (c < -128) c = -128;
      end
      apply(a, b, c, d, "R8 R9 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule